// File: doc/BRIEF.md
# Counter-Driven Weighted Round-Robin Cell Scheduler

This block picks one virtual circuit for each cell slot on an outgoing link. Each circuit is given an integer weight, and over one scheduling frame of `2^CNT_W` slots it receives a number of slots equal to that weight. A slot counter steps once per slot tick. Its value is bit-reversed and compared at the same time against the slot range of every circuit, in the way a content-addressable memory compares a key against all of its entries. The ranges are laid end to end in bit-reversed space, so a circuit's slots come out evenly spaced in real time and not in a single burst.

When the circuit that owns the current slot has no cell ready, or when no circuit owns that slot, the slot goes to the next ready circuit after the one granted last. No slot is wasted while any circuit can send, so spare bandwidth goes only to the circuits that can use it. Software loads the weights through a one-word write port. A write that would make the sum of all weights larger than the frame is dropped.

Top module: `wrr_sched_top`

## Requirements
- R1: The block makes one decision for each cycle in which `slot_tick` is high. The result appears on `grant_vld`/`grant_idx` in the next cycle, and `grant_vld` is high only in that cycle. The slot counter advances by one per tick and wraps modulo `2^CNT_W`.
- R2: Whenever `grant_vld` is high, `grant_idx` names a circuit whose `ready` bit was high in the tick cycle.
- R3: A tick with at least one `ready` bit high always produces a grant. A tick with `ready` all zero leaves `grant_vld` low, and the slot counter still advances.
- R4: Circuit i owns the bit-reversed counter values from B_i to B_i + W_i - 1, where W_i is its weight and B_i is the sum of the weights of circuits 0 to i-1. Bit j of the counter maps to bit `CNT_W-1-j` of the reversed value. When the reversed counter falls inside a ready circuit's range, that circuit is granted.
- R5: The fallback applies when the reversed counter lies in the range of a circuit that is not ready, or in no range at all. In either case the grant goes to the first ready circuit after the last granted one, searching upward in index order and wrapping from `NUM_VC-1` to 0.
- R6: A write (`wr_en` high) whose new weight would push the sum of all weights above `2^CNT_W` is refused, and every stored weight stays unchanged.
- R7: A write that keeps the sum at or below `2^CNT_W` is accepted, and this includes a sum exactly equal to the limit. It governs every tick from the following cycle onward.
- R8: While `rst_n` is low, `grant_vld` is 0 and `grant_idx` is 0. After reset all weights are zero, the counter is zero, and the last granted circuit is taken to be `NUM_VC-1`, so the first fallback grant goes to the lowest ready index.
- R9: `grant_idx` keeps its value in every cycle that does not follow a tick that produced a grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| slot_tick | input | 1 | Start of a cell slot: make one decision |
| ready | input | NUM_VC | Bit i is high when circuit i has a cell to send |
| wr_en | input | 1 | Weight write strobe |
| wr_idx | input | IDX_W | Circuit whose weight is written |
| wr_weight | input | CNT_W+1 | New weight in slots per frame |
| grant_idx | output | IDX_W | Circuit granted in the last slot |
| grant_vld | output | 1 | One-cycle pulse: `grant_idx` is a new grant |

## Verification
Both the grant and its valid flag are registered, so each tick's result is due exactly one clock edge after the tick. A weight write takes effect for a tick presented in the next cycle or any later one. The bench drives every input on a falling edge, holds the tick for one cycle, and reads the outputs on the following falling edge, which is half a period after the edge that registered them. Because the slot counter moves only on ticks, the bench tracks the counter value for each tick itself. From that value it works out by hand the reversed position and the owner of the slot.

// File: rtl/wrr_pkg.sv
// Package: shared helpers for the weighted round-robin scheduler.
// Assumes: widths passed to bit_rev never exceed 32.
package wrr_pkg;

    // Reverse the low 'w' bits of 'v'; bits at w and above come back zero.
    function automatic logic [31:0] bit_rev(input logic [31:0] v, input int unsigned w);
        logic [31:0] r;
        r = '0;
        for (int unsigned j = 0; j < w; j++) begin
            r[w-1-j] = v[j];
        end
        return r;
    endfunction

endpackage

// File: rtl/wrr_weight_table.sv
// Module: per-circuit weight storage with admission control.
// Keeps one weight per circuit and derives each circuit's range base
// (prefix sum of lower-indexed weights) and the total of all weights.
// A write is dropped if the new total would exceed FRAME.
// Assumes: stored total never exceeds FRAME, so WGT_W bits hold any sum.
module wrr_weight_table #(
    parameter int NUM_VC = 8,
    parameter int CNT_W  = 6,
    parameter int IDX_W  = 3,
    parameter int WGT_W  = 7
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic [WGT_W-1:0]                  wr_weight,
    output logic [NUM_VC-1:0][WGT_W-1:0]      weight,
    output logic [NUM_VC-1:0][WGT_W-1:0]      base,
    output logic [WGT_W-1:0]                  total
);
    localparam int unsigned FRAME = 1 << CNT_W;

    logic [WGT_W-1:0] old_w;
    logic [WGT_W:0]   new_total;
    logic             idx_ok;
    logic             accept;

    // Prefix-sum chain giving each circuit the start of its range.
    assign base[0] = '0;
    for (genvar i = 1; i < NUM_VC; i++) begin : g_base
        assign base[i] = base[i-1] + weight[i-1];
    end
    assign total = base[NUM_VC-1] + weight[NUM_VC-1];

    // Look up the weight currently held by the addressed circuit.
    always_comb begin
        old_w = '0;
        for (int i = 0; i < NUM_VC; i++) begin
            if (wr_idx == IDX_W'(i)) old_w = weight[i];
        end
    end

    // Admission test: the total after the write must stay within one frame.
    assign idx_ok    = (int'(wr_idx) < NUM_VC);
    assign new_total = {1'b0, total} - {1'b0, old_w} + {1'b0, wr_weight};
    assign accept    = wr_en && idx_ok && (new_total <= (WGT_W+1)'(FRAME));

    // Weight registers: cleared by reset, loaded on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            weight <= '0;
        end else if (accept) begin
            for (int i = 0; i < NUM_VC; i++) begin
                if (wr_idx == IDX_W'(i)) weight[i] <= wr_weight;
            end
        end
    end

endmodule

// File: rtl/wrr_range_match.sv
// Module: associative range lookup.
// Compares the bit-reversed slot position against every circuit's range
// in parallel and reports the single owning circuit, if any.
// Assumes: ranges do not overlap (guaranteed by the admission limit).
module wrr_range_match #(
    parameter int NUM_VC = 8,
    parameter int IDX_W  = 3,
    parameter int WGT_W  = 7
) (
    input  logic [WGT_W-1:0]              pos,
    input  logic [NUM_VC-1:0][WGT_W-1:0]  weight,
    input  logic [NUM_VC-1:0][WGT_W-1:0]  base,
    output logic                          hit,
    output logic [IDX_W-1:0]              hit_idx
);
    logic [NUM_VC-1:0] hit_vec;

    // One comparator pair per circuit: base <= pos < base + weight.
    for (genvar i = 0; i < NUM_VC; i++) begin : g_cmp
        logic [WGT_W:0] lim;
        assign lim        = {1'b0, base[i]} + {1'b0, weight[i]};
        assign hit_vec[i] = (pos >= base[i]) && ({1'b0, pos} < lim);
    end

    // Encode the matching line into an index.
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < NUM_VC; i++) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end
    assign hit = |hit_vec;

endmodule

// File: rtl/wrr_rr_pick.sv
// Module: round-robin fallback selector.
// Finds the first ready circuit after 'last', searching upward and wrapping.
// Assumes: last < NUM_VC.
module wrr_rr_pick #(
    parameter int NUM_VC = 8,
    parameter int IDX_W  = 3
) (
    input  logic [NUM_VC-1:0] ready,
    input  logic [IDX_W-1:0]  last,
    output logic              found,
    output logic [IDX_W-1:0]  pick
);
    // Rotating priority scan starting just after the last grant.
    always_comb begin
        int c;
        found = 1'b0;
        pick  = '0;
        c     = 0;
        for (int k = 1; k <= NUM_VC; k++) begin
            c = (int'(last) + k) % NUM_VC;
            if (!found && ready[c]) begin
                found = 1'b1;
                pick  = IDX_W'(c);
            end
        end
    end

endmodule

// File: rtl/wrr_sched_top.sv
// Module: weighted round-robin cell scheduler, top level.
// A slot counter steps per tick; its bit-reversed value selects the owning
// circuit through a parallel range match. A non-ready or absent owner
// hands the slot to the round-robin fallback. Grants are registered.
// Assumes: slot_tick is a single-cycle strobe per cell slot; CNT_W <= 31.
module wrr_sched_top #(
    parameter int NUM_VC = 8,
    parameter int CNT_W  = 6,
    localparam int IDX_W = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
    localparam int WGT_W = CNT_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               slot_tick,
    input  logic [NUM_VC-1:0]  ready,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [WGT_W-1:0]   wr_weight,
    output logic [IDX_W-1:0]   grant_idx,
    output logic               grant_vld
);
    import wrr_pkg::*;

    logic [CNT_W-1:0]               slot_cnt;
    logic [WGT_W-1:0]               rev_pos;
    logic [NUM_VC-1:0][WGT_W-1:0]   w_val;
    logic [NUM_VC-1:0][WGT_W-1:0]   w_base;
    logic [WGT_W-1:0]               w_total;
    logic                           m_hit;
    logic [IDX_W-1:0]               m_idx;
    logic                           rr_found;
    logic [IDX_W-1:0]               rr_idx;
    logic [IDX_W-1:0]               last_idx;
    logic                           sel_vld;
    logic [IDX_W-1:0]               sel_idx;
    logic [31:0]                    rev_full;

    wrr_weight_table #(
        .NUM_VC(NUM_VC), .CNT_W(CNT_W), .IDX_W(IDX_W), .WGT_W(WGT_W)
    ) wtab_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_weight(wr_weight), .weight(w_val), .base(w_base), .total(w_total)
    );

    // Reversed slot position, zero-extended to weight width.
    assign rev_full = bit_rev({{(32-CNT_W){1'b0}}, slot_cnt}, CNT_W);
    assign rev_pos  = {1'b0, rev_full[CNT_W-1:0]};

    wrr_range_match #(
        .NUM_VC(NUM_VC), .IDX_W(IDX_W), .WGT_W(WGT_W)
    ) match_i (
        .pos(rev_pos), .weight(w_val), .base(w_base), .hit(m_hit), .hit_idx(m_idx)
    );

    wrr_rr_pick #(
        .NUM_VC(NUM_VC), .IDX_W(IDX_W)
    ) rr_i (
        .ready(ready), .last(last_idx), .found(rr_found), .pick(rr_idx)
    );

    // Decision: owner if ready, otherwise the round-robin fallback.
    always_comb begin
        if (m_hit && ready[m_idx]) begin
            sel_vld = 1'b1;
            sel_idx = m_idx;
        end else begin
            sel_vld = rr_found;
            sel_idx = rr_idx;
        end
    end

    // Slot counter: one step per tick, free wrap at the frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) slot_cnt <= '0;
        else if (slot_tick) slot_cnt <= slot_cnt + 1'b1;
    end

    // Grant outputs and last-grant memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_vld <= 1'b0;
            grant_idx <= '0;
            last_idx  <= IDX_W'(NUM_VC - 1);
        end else begin
            grant_vld <= slot_tick && sel_vld;
            if (slot_tick && sel_vld) begin
                grant_idx <= sel_idx;
                last_idx  <= sel_idx;
            end
        end
    end

endmodule

// File: rtl/wrr_sched_chk.sv
// Module: temporal checks for the scheduler, bound into the top module.
// Assumes: same parameters as the bound instance.
module wrr_sched_chk #(
    parameter int NUM_VC = 8,
    parameter int CNT_W  = 6,
    parameter int IDX_W  = 3,
    parameter int WGT_W  = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               slot_tick,
    input logic [NUM_VC-1:0]  ready,
    input logic [IDX_W-1:0]   grant_idx,
    input logic               grant_vld,
    input logic [WGT_W-1:0]   total,
    input logic [CNT_W-1:0]   cnt
);
    localparam int unsigned FRAME = 1 << CNT_W;

    logic [NUM_VC-1:0] ready_q;

    // Keep the ready vector seen on the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= '0;
        else ready_q <= ready;
    end

    p_vld_after_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |-> $past(slot_tick));

    p_cnt_moves_r1: assert property (@(posedge clk) disable iff (!rst_n)
        slot_tick |=> (cnt != $past(cnt)));

    p_cnt_still_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_tick |=> $stable(cnt));

    p_grant_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |-> ready_q[grant_idx]);

    p_no_waste_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_tick && (|ready)) |=> grant_vld);

    p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_tick && (ready == '0)) |=> !grant_vld);

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        total <= WGT_W'(FRAME));

    p_hold_idx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_tick |=> $stable(grant_idx));

endmodule

bind wrr_sched_top wrr_sched_chk #(
    .NUM_VC(NUM_VC), .CNT_W(CNT_W), .IDX_W(IDX_W), .WGT_W(WGT_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .ready(ready),
    .grant_idx(grant_idx), .grant_vld(grant_vld), .total(w_total), .cnt(slot_cnt)
);

// File: tb/wrr_sched_top_tb_top.sv
// Bench: 4 circuits, 3-bit counter (8-slot frame). Table walk, then directed.
module wrr_sched_top_tb_top;
    localparam int NV = 4;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          slot_tick = 1'b0;
    logic [NV-1:0] ready = '0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_idx = '0;
    logic [CW:0]   wr_weight = '0;
    logic [1:0]    grant_idx;
    logic          grant_vld;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wrr_sched_top #(.NUM_VC(NV), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .ready(ready),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_weight(wr_weight),
        .grant_idx(grant_idx), .grant_vld(grant_vld)
    );

    // Row = {ready[3:0], expected vld, expected idx[1:0]}.
    // Weights 4,2,1,1 -> reversed ranges c0 0..3, c1 4..5, c2 6, c3 7.
    localparam logic [6:0] TAB [21] = '{
        7'b1111_1_00, 7'b1111_1_01, 7'b1111_1_00, 7'b1111_1_10,
        7'b1111_1_00, 7'b1111_1_01, 7'b1111_1_00, 7'b1111_1_11,
        7'b1110_1_01, 7'b1110_1_01, 7'b1110_1_10, 7'b1110_1_10,
        7'b1110_1_11, 7'b1110_1_01, 7'b1110_1_10, 7'b1110_1_11,
        7'b0000_0_11, 7'b0000_0_11, 7'b0100_1_10, 7'b1111_1_10,
        7'b1111_1_00
    };

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Present one tick at a falling edge; sample one edge later.
    task automatic tick(input logic [NV-1:0] rdy);
        ready = rdy;
        slot_tick = 1'b1;
        @(negedge clk);
        slot_tick = 1'b0;
    endtask

    task automatic wr(input int idx, input int w);
        wr_en = 1'b1;
        wr_idx = 2'(idx);
        wr_weight = (CW+1)'(w);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R8 vld in reset", int'(grant_vld), 0);
        check("R8 idx in reset", int'(grant_idx), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R7: loading to exactly the frame total is accepted.
        wr(0, 4); wr(1, 2); wr(2, 1); wr(3, 1);

        for (int i = 0; i < 21; i++) begin
            string tg;
            tick(TAB[i][6:3]);
            if (i < 8) tg = "R4 R7 owner";
            else if (i < 16) tg = "R5 R2 fallback";
            else if (i < 18) tg = "R3 R9 idle";
            else tg = "R3 R4 resume";
            check({tg, " vld"}, int'(grant_vld), int'(TAB[i][2]));
            check({tg, " idx"}, int'(grant_idx), int'(TAB[i][1:0]));
        end

        // R1: pulse lasts one cycle only.
        @(negedge clk);
        check("R1 pulse width", int'(grant_vld), 0);

        // R6: w0=5 would make total 9 > 8; counter 5 -> rev 5 stays with c1.
        wr(0, 5);
        tick(4'b1111);
        check("R6 refused write", int'(grant_idx), 1);
        // R7: w0=3 -> c0 0..2, c1 3..4, c2 5, c3 6, 7 unowned.
        wr(0, 3);
        tick(4'b1111);
        check("R7 accepted write", int'(grant_idx), 1);
        tick(4'b1111);
        check("R5 unowned slot", int'(grant_idx), 2);

        // R8: reset clears weights, counter and last grant.
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 vld after reset", int'(grant_vld), 0);
        check("R8 idx after reset", int'(grant_idx), 0);
        rst_n = 1'b1;
        tick(4'b1010);
        check("R8 first fallback", int'(grant_idx), 1);
        tick(4'b1010);
        check("R5 wrap scan", int'(grant_idx), 3);
        tick(4'b1111);
        check("R8 weights cleared a", int'(grant_idx), 0);
        tick(4'b1111);
        check("R8 weights cleared b", int'(grant_idx), 1);

        done = 1'b1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

endmodule